// File: doc/BRIEF.md
# Memory Buffer Reset Sequencer

This controller drives the reset and start-up outputs of a memory buffer chip that talks to its host over a serial link. It has two ways into reset. A cold reset starts from an active-low reset pin that is held low while the supplies ramp. Everything is held in reset at that point, and the DRAM clock-enable is kept low. After the pin is released, a timed quiet window runs. Then a sideband phase opens, in which the link frequency, transmitter settings and personality bytes are written. Link initialisation is enabled only after the sideband side reports that it is done. While the pin is low, the block also checks how long the reference clock has been reported stable. It sets a violation flag if the pin is released too early.

The second path is a fast reset. It starts when electrical idle is seen on the primary downstream link. The sequencer first asks the DRAMs to enter self-refresh and waits for the acknowledge. A timeout guards this wait and sets an error flag if it expires. Only then does it assert the non-sticky core reset for a minimum hold time. The PLL reset and the sticky reset stay released throughout. The sequencer returns to the link state once idle has gone.

States:
- `ST_COLD`: pin reset.
- `ST_QUIET`: quiet window.
- `ST_SBPROG`: sideband programming.
- `ST_LINK`: link init enabled.
- `ST_FR_SREQ`: self-refresh request.
- `ST_FR_RST`: fast-reset hold.

Transitions:
- COLD to QUIET on the first clock after the synchronised pin release.
- QUIET to SBPROG when the quiet timer expires.
- SBPROG to LINK on `sb_done`.
- LINK to FR_SREQ on synchronised idle.
- FR_SREQ to FR_RST on synchronised acknowledge or timeout.
- FR_RST to LINK when the hold timer has expired and idle is gone.

Top module: `mbuf_rst_seq`

## Requirements
- R1: While `rst_pin_n` is low, `core_rst`, `sticky_rst` and `pll_rst` are 1, and `dram_cke`, `sb_en`, `link_init_en`, `sr_req`, `refclk_viol` and `sr_to_err` are 0.
- R2: `refclk_viol` is set after pin release if `refclk_ok` had been high for fewer than `REFCLK_MIN_CYC` consecutive cycles at release. It is 0 otherwise, and it stays as set until the next pin reset.
- R3: After `core_rst` falls on a cold reset, exactly `QUIET_CYC` cycles pass with `sb_en` and `dram_cke` at 0 before `sb_en` rises.
- R4: In the sideband phase, the first write with `sb_wr_addr == LINKFREQ_ADDR` makes `pll_init_pulse` 1 for one cycle, and `pll_rst` falls at the same time. A write during the quiet window has no effect on either output.
- R5: `link_init_en` and `dram_cke` stay 0 in the sideband phase. Both become 1 in the cycle after a one-cycle `sb_done` pulse.
- R6: On link idle, `sr_req` rises while `core_rst` stays 0 and `dram_cke` stays 1 until the self-refresh acknowledge is seen.
- R7: During a fast reset only `core_rst` is asserted, and `sticky_rst` and `pll_rst` stay 0. With idle already gone, `core_rst` is high for exactly `FR_HOLD_CYC` cycles, and then `link_init_en` returns to 1 with `sr_req` at 0.
- R8: Without an acknowledge, `sr_req` is high with `core_rst` low for exactly `SR_TIMEOUT_CYC` cycles, after which `core_rst` rises and `sr_to_err` becomes 1. A fast reset that is acknowledged leaves `sr_to_err` at 0.
- R9: Link idle seen before the link state (in the quiet window or the sideband phase) is ignored: `sr_req` and `core_rst` stay 0.
- R10: Asynchronous inputs pass through two flops, so `sr_req` rises in the third cycle after `link_eidle` rises in the link state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_pin_n | input | 1 | Active-low cold reset pin, asynchronous |
| refclk_ok | input | 1 | Reference clock stable flag, asynchronous |
| link_eidle | input | 1 | Electrical idle on primary downstream link, asynchronous |
| sr_ack | input | 1 | DRAM self-refresh acknowledge, asynchronous |
| sb_wr_valid | input | 1 | Sideband register write strobe, synchronous |
| sb_wr_addr | input | ADDR_W | Sideband register write address |
| sb_done | input | 1 | Sideband programming complete pulse |
| dram_cke | output | 1 | DRAM clock-enable |
| sr_req | output | 1 | Self-refresh request |
| core_rst | output | 1 | Non-sticky reset |
| sticky_rst | output | 1 | Sticky flop and register reset |
| pll_rst | output | 1 | PLL reset |
| pll_init_pulse | output | 1 | One-cycle PLL start pulse on link-frequency write |
| sb_en | output | 1 | Sideband access enable |
| link_init_en | output | 1 | Link initialisation enable |
| refclk_viol | output | 1 | Reference clock stable time too short at release |
| sr_to_err | output | 1 | Self-refresh handshake timed out |

## Verification
The assertions assume the following about the inputs:
- `sb_done` and `sb_wr_valid` are synchronous to `clk`.
- `sb_done` is a single-cycle pulse.
- `link_eidle` and `sr_ack`, once raised, are held for several cycles, which is more than the two-flop synchroniser latency.

The stimulus drives every input on the falling clock edge. It holds idle and acknowledge for many cycles and keeps the pin low long enough for the reference-clock count to saturate, or deliberately not to saturate in the violation case.

// File: rtl/mbrs_pkg.sv
package mbrs_pkg;
    typedef enum logic [2:0] {
        ST_COLD,
        ST_QUIET,
        ST_SBPROG,
        ST_LINK,
        ST_FR_SREQ,
        ST_FR_RST
    } seq_state_e;
endpackage

// File: rtl/mbrs_sync.sv
module mbrs_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta;
        logic stab;
        always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) begin
                meta <= 1'b0;
                stab <= 1'b0;
            end else begin
                meta <= d[i];
                stab <= meta;
            end
        end
        assign q[i] = stab;
    end
endmodule

// File: rtl/mbrs_timer.sv
module mbrs_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] ld_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= ld_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired); // R3
endmodule

// File: rtl/mbrs_satcnt.sv
module mbrs_satcnt #(
    parameter int unsigned MAX = 16
) (
    input  logic clk,
    input  logic run,
    output logic at_max
);
    localparam int unsigned W = $clog2(MAX + 1);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!run)                 cnt <= '0;
        else if (cnt != W'(MAX))  cnt <= cnt + 1'b1;
    end

    assign at_max = (cnt == W'(MAX));
endmodule

// File: rtl/mbuf_rst_seq.sv
module mbuf_rst_seq
    import mbrs_pkg::*;
#(
    parameter int unsigned REFCLK_MIN_CYC = 250000,
    parameter int unsigned QUIET_CYC      = 50000,
    parameter int unsigned SR_TIMEOUT_CYC = 1024,
    parameter int unsigned FR_HOLD_CYC    = 16,
    parameter int unsigned ADDR_W         = 8,
    parameter logic [ADDR_W-1:0] LINKFREQ_ADDR = ADDR_W'(64)
) (
    input  logic              clk,
    input  logic              rst_pin_n,
    input  logic              refclk_ok,
    input  logic              link_eidle,
    input  logic              sr_ack,
    input  logic              sb_wr_valid,
    input  logic [ADDR_W-1:0] sb_wr_addr,
    input  logic              sb_done,
    output logic              dram_cke,
    output logic              sr_req,
    output logic              core_rst,
    output logic              sticky_rst,
    output logic              pll_rst,
    output logic              pll_init_pulse,
    output logic              sb_en,
    output logic              link_init_en,
    output logic              refclk_viol,
    output logic              sr_to_err
);
    localparam int unsigned TMR_MAX_A = (QUIET_CYC > SR_TIMEOUT_CYC) ? QUIET_CYC : SR_TIMEOUT_CYC;
    localparam int unsigned TMR_MAX   = (TMR_MAX_A > FR_HOLD_CYC) ? TMR_MAX_A : FR_HOLD_CYC;
    localparam int unsigned TMR_W     = $clog2(TMR_MAX + 1);

    logic       rst_n_s;
    logic [2:0] async_s;
    logic       refclk_s, eidle_s, ack_s;
    logic       rc_ok;
    logic       tmr_load, tmr_exp;
    logic [TMR_W-1:0] tmr_val;
    logic       pll_up;
    logic       lf_write;
    seq_state_e state, state_n;

    // reset pin: asynchronous assert, synchronous release
    mbrs_sync #(.W(1)) u_pin_sync (
        .clk(clk), .clr_n(rst_pin_n), .d(1'b1), .q(rst_n_s)
    );

    mbrs_sync #(.W(3)) u_in_sync (
        .clk(clk), .clr_n(1'b1),
        .d({refclk_ok, link_eidle, sr_ack}), .q(async_s)
    );
    assign {refclk_s, eidle_s, ack_s} = async_s;

    mbrs_satcnt #(.MAX(REFCLK_MIN_CYC)) u_refclk_cnt (
        .clk(clk), .run(refclk_s), .at_max(rc_ok)
    );

    mbrs_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n_s), .load(tmr_load), .ld_val(tmr_val), .expired(tmr_exp)
    );

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_COLD:    state_n = ST_QUIET;
            ST_QUIET:   if (tmr_exp) state_n = ST_SBPROG;
            ST_SBPROG:  if (sb_done) state_n = ST_LINK;
            ST_LINK:    if (eidle_s) state_n = ST_FR_SREQ;
            ST_FR_SREQ: if (ack_s || tmr_exp) state_n = ST_FR_RST;
            ST_FR_RST:  if (tmr_exp && !eidle_s) state_n = ST_LINK;
            default:    state_n = ST_COLD;
        endcase
    end

    always_comb begin
        tmr_load = (state_n != state);
        unique case (state_n)
            ST_QUIET:   tmr_val = TMR_W'(QUIET_CYC - 1);
            ST_FR_SREQ: tmr_val = TMR_W'(SR_TIMEOUT_CYC - 1);
            ST_FR_RST:  tmr_val = TMR_W'(FR_HOLD_CYC - 1);
            default:    tmr_val = '0;
        endcase
    end

    assign lf_write = (state == ST_SBPROG) && !pll_up && sb_wr_valid
                    && (sb_wr_addr == LINKFREQ_ADDR);

    // state register and flags
    always_ff @(posedge clk or negedge rst_n_s) begin
        if (!rst_n_s) begin
            state          <= ST_COLD;
            pll_up         <= 1'b0;
            pll_init_pulse <= 1'b0;
            refclk_viol    <= 1'b0;
            sr_to_err      <= 1'b0;
        end else begin
            state          <= state_n;
            pll_init_pulse <= lf_write;
            if (lf_write || (state == ST_SBPROG && sb_done)) pll_up <= 1'b1;
            if (state == ST_COLD) refclk_viol <= !rc_ok;
            if (state == ST_FR_SREQ && !ack_s && tmr_exp) sr_to_err <= 1'b1;
        end
    end

    // outputs decoded from state
    always_comb begin
        core_rst     = 1'b0;
        sticky_rst   = 1'b0;
        dram_cke     = 1'b0;
        sr_req       = 1'b0;
        sb_en        = 1'b0;
        link_init_en = 1'b0;
        unique case (state)
            ST_COLD:    begin core_rst = 1'b1; sticky_rst = 1'b1; end
            ST_QUIET:   ;
            ST_SBPROG:  sb_en = 1'b1;
            ST_LINK:    begin sb_en = 1'b1; dram_cke = 1'b1; link_init_en = 1'b1; end
            ST_FR_SREQ: begin sb_en = 1'b1; dram_cke = 1'b1; sr_req = 1'b1; end
            ST_FR_RST:  begin sb_en = 1'b1; sr_req = 1'b1; core_rst = 1'b1; end
            default:    ;
        endcase
    end
    assign pll_rst = !pll_up;

    AST_RST_AFTER_SREQ: assert property (@(posedge clk) disable iff (!rst_n_s)
        $rose(core_rst) |-> $past(sr_req)); // R6
    AST_STICKY_KEPT: assert property (@(posedge clk) disable iff (!rst_n_s)
        !$past(sticky_rst) |-> !sticky_rst); // R7
    AST_PLL_KEPT: assert property (@(posedge clk) disable iff (!rst_n_s)
        !$past(pll_rst) |-> !pll_rst); // R7
    AST_LINK_GATED: assert property (@(posedge clk) disable iff (!rst_n_s)
        $rose(link_init_en) |-> ($past(sb_done) || $past(core_rst))); // R5
    AST_PULSE_FROM_RESET: assert property (@(posedge clk) disable iff (!rst_n_s)
        pll_init_pulse |-> $past(pll_rst)); // R4
    AST_TIMEOUT_RESETS: assert property (@(posedge clk) disable iff (!rst_n_s)
        $rose(sr_to_err) |-> core_rst); // R8
endmodule

// File: tb/mbuf_rst_seq_test.sv
module mbuf_rst_seq_test;
    localparam int RC_MIN = 20;
    localparam int QUIET  = 16;
    localparam int SR_TO  = 10;
    localparam int HOLD   = 4;
    localparam logic [7:0] LF_ADDR = 8'h40;

    logic clk = 1'b0;
    logic rst_pin_n = 1'b0, refclk_ok = 1'b0, link_eidle = 1'b0, sr_ack = 1'b0;
    logic sb_wr_valid = 1'b0, sb_done = 1'b0;
    logic [7:0] sb_wr_addr = 8'h00;
    logic dram_cke, sr_req, core_rst, sticky_rst, pll_rst, pll_init_pulse;
    logic sb_en, link_init_en, refclk_viol, sr_to_err;
    int checks = 0, failures = 0;

    always #2 clk = ~clk;

    mbuf_rst_seq #(
        .REFCLK_MIN_CYC(RC_MIN), .QUIET_CYC(QUIET), .SR_TIMEOUT_CYC(SR_TO),
        .FR_HOLD_CYC(HOLD), .ADDR_W(8), .LINKFREQ_ADDR(LF_ADDR)
    ) uut (
        .clk(clk), .rst_pin_n(rst_pin_n), .refclk_ok(refclk_ok), .link_eidle(link_eidle),
        .sr_ack(sr_ack), .sb_wr_valid(sb_wr_valid), .sb_wr_addr(sb_wr_addr), .sb_done(sb_done),
        .dram_cke(dram_cke), .sr_req(sr_req), .core_rst(core_rst), .sticky_rst(sticky_rst),
        .pll_rst(pll_rst), .pll_init_pulse(pll_init_pulse), .sb_en(sb_en),
        .link_init_en(link_init_en), .refclk_viol(refclk_viol), .sr_to_err(sr_to_err)
    );

    task automatic check(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic cold_reset(int lead);
        rst_pin_n = 1'b0; refclk_ok = 1'b0; link_eidle = 1'b0; sr_ack = 1'b0;
        repeat (5) @(negedge clk);
        check("R1 core_rst", core_rst, 1);
        check("R1 sticky_rst", sticky_rst, 1);
        check("R1 pll_rst", pll_rst, 1);
        check("R1 outputs low", {dram_cke, sb_en, link_init_en, sr_req, sr_to_err}, 0);
        check("R2 viol cleared in reset", refclk_viol, 0);
        refclk_ok = 1'b1;
        repeat (lead) @(negedge clk);
        rst_pin_n = 1'b1;
        for (int i = 0; i < 20 && core_rst; i++) @(negedge clk);
        check("R1 core_rst released", core_rst, 0);
    endtask

    task automatic t_cold_ok;
        int n;
        cold_reset(40);
        check("R2 no violation", refclk_viol, 0);
        // write to link-frequency during the quiet window
        sb_wr_valid = 1'b1; sb_wr_addr = LF_ADDR;
        @(negedge clk);
        sb_wr_valid = 1'b0;
        check("R4 quiet write no pulse", pll_init_pulse, 0);
        check("R4 quiet write pll_rst held", pll_rst, 1);
        n = 2;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (sb_en) break;
            if (dram_cke) check("R3 cke low in quiet", dram_cke, 0);
            n++;
        end
        check("R3 quiet length", n, QUIET);
        // idle during the sideband phase
        link_eidle = 1'b1;
        repeat (6) @(negedge clk);
        link_eidle = 1'b0;
        repeat (4) @(negedge clk);
        check("R9 idle ignored sr_req", sr_req, 0);
        check("R9 idle ignored core_rst", core_rst, 0);
        check("R5 link off in sideband", {link_init_en, dram_cke}, 0);
        sb_wr_valid = 1'b1; sb_wr_addr = LF_ADDR;
        @(negedge clk);
        sb_wr_valid = 1'b0;
        check("R4 pulse", pll_init_pulse, 1);
        check("R4 pll_rst released", pll_rst, 0);
        @(negedge clk);
        check("R4 pulse one cycle", pll_init_pulse, 0);
        repeat (3) @(negedge clk);
        check("R5 link still off", link_init_en, 0);
        sb_done = 1'b1;
        @(negedge clk);
        sb_done = 1'b0;
        check("R5 link_init_en", link_init_en, 1);
        check("R5 dram_cke", dram_cke, 1);
    endtask

    task automatic t_fast_ack;
        int n;
        link_eidle = 1'b1;
        n = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            n++;
            if (sr_req) break;
        end
        check("R10 sync latency", n, 3);
        check("R6 no reset before ack", core_rst, 0);
        repeat (3) @(negedge clk);
        check("R6 still waiting", {core_rst, dram_cke, sr_req}, 3'b011);
        link_eidle = 1'b0; sr_ack = 1'b1;
        for (int i = 0; i < 20 && !core_rst; i++) @(negedge clk);
        n = 0;
        for (int i = 0; i < 100 && core_rst; i++) begin
            if (sticky_rst || pll_rst) check("R7 sticky/pll kept", {sticky_rst, pll_rst}, 0);
            n++;
            @(negedge clk);
        end
        sr_ack = 1'b0;
        check("R7 hold length", n, HOLD);
        check("R7 back to link", {link_init_en, sr_req}, 2'b10);
        check("R8 no error on ack", sr_to_err, 0);
    endtask

    task automatic t_fast_timeout;
        int n;
        link_eidle = 1'b1;
        for (int i = 0; i < 20 && !sr_req; i++) @(negedge clk);
        n = 1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (core_rst || !sr_req) break;
            n++;
        end
        check("R8 timeout length", n, SR_TO);
        check("R8 reset after timeout", core_rst, 1);
        check("R8 error flag", sr_to_err, 1);
        repeat (HOLD + 3) @(negedge clk);
        check("R7 held while idle", core_rst, 1);
        check("R7 sticky/pll after timeout", {sticky_rst, pll_rst}, 0);
        link_eidle = 1'b0;
        for (int i = 0; i < 20 && !link_init_en; i++) @(negedge clk);
        check("R7 link after idle gone", link_init_en, 1);
    endtask

    task automatic t_refclk_short;
        cold_reset(5);
        check("R2 violation flagged", refclk_viol, 1);
        repeat (4) @(negedge clk);
        check("R2 violation held", refclk_viol, 1);
    endtask

    initial begin
        t_cold_ok();
        t_fast_ack();
        t_fast_timeout();
        t_refclk_short();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule